// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block generates the address stream for one DMA channel. A transfer frame consists of a number of arrays, each a fixed number of bytes long. Inside an array the source and destination byte addresses both climb by one per byte from the array's start addresses. From one array to the next, the source start address and the destination start address each move by their own signed stride. A stride may be zero, so that side returns to the same window for every array. This lets a fixed data port, such as a flash data register, be read into a walking memory buffer, or filled from one.

The sequencer emits one beat per clock cycle to a data mover. Each beat carries a source address, a destination address and a byte count of at most `MAX_BEAT` bytes, so an array longer than the mover's width is split into several beats. Software loads the frame parameters while the channel is idle, which arms the channel. Synchronization events then release the beats, either a whole frame per event or a single array per event. A one-cycle completion pulse marks the end of the frame.

Top module: `dma2d_addr_seq`

## Requirements
- R1: A `cfg_load` seen while the channel is idle captures all parameters and arms the channel. The load is ignored if the array length or the array count is zero, or if the channel is already armed or running.
- R2: Beats of one array follow each other with no gap. Each beat carries min(`MAX_BEAT`, bytes left in the array) bytes and has a count of at least 1. The next beat's source and destination are the previous ones plus that count, and the first beat of an array starts at offset 0.
- R3: The start of array k+1 equals the start of array k plus the stride for that side, sign-extended to the address width. A zero stride repeats the same start address.
- R4: In frame mode (`cfg_ab_sync`=1), one event releases all arrays back to back, ACNT×BCNT bytes in total. The first beat appears in the cycle after the event is sampled.
- R5: In array mode (`cfg_ab_sync`=0), one event releases exactly one array. Output then goes quiet until the next event, and the array and offset counters keep their values.
- R6: `done` is high for exactly one cycle: the cycle right after the last beat of the frame. After that the channel is idle and unarmed. After reset, `beat_valid` and `done` are low.
- R7: `sync_evt` is ignored while the channel is idle and unarmed, and while it is already emitting beats. Holding `sync_evt` high during or after a frame adds no beats.
- R8: Strides are signed 16-bit two's-complement values, so negative strides walk addresses downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load parameters and arm (idle only) |
| cfg_src | input | ADDR_W | Source start address of the first array |
| cfg_dst | input | ADDR_W | Destination start address of the first array |
| cfg_acnt | input | 16 | Bytes per array |
| cfg_bcnt | input | 16 | Arrays per frame |
| cfg_sidx | input | 16 | Signed source stride between arrays |
| cfg_didx | input | 16 | Signed destination stride between arrays |
| cfg_ab_sync | input | 1 | 1: frame per event, 0: array per event |
| sync_evt | input | 1 | Synchronization event |
| beat_valid | output | 1 | Beat fields are valid this cycle |
| beat_src | output | ADDR_W | Source byte address of the beat |
| beat_dst | output | ADDR_W | Destination byte address of the beat |
| beat_len | output | $clog2(MAX_BEAT+1) | Byte count of the beat |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
A corrupted offset counter shows up on the next beat as a wrong address or a wrong byte count. A wrong array start register shows up on the first beat of the following array. A miscounted array index shows up at the end of the frame: `done` arrives at the wrong time, beats are missing, or extra beats appear. A controller in the wrong state shows up within one cycle of an event, as beats that start too early, start too late, or never stop. The directed tests therefore compare every beat field in every cycle of a frame. They also check that output stays quiet in the cycles around events that must be ignored.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  parameter int CNT_W = 16;
  parameter int IDX_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } chan_state_e;

  typedef struct packed {
    logic [CNT_W-1:0] acnt;
    logic [CNT_W-1:0] bcnt;
    logic [IDX_W-1:0] sidx;
    logic [IDX_W-1:0] didx;
    logic             ab_mode;
  } chan_cfg_t;
endpackage

// File: rtl/dma2d_cfg_regs.sv
module dma2d_cfg_regs
  import dma2d_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  chan_cfg_t cfg_in,
  output chan_cfg_t cfg_q
);
  chan_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (capture) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/dma2d_fsm.sv
module dma2d_fsm
  import dma2d_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic        cfg_ok,
  input  logic        sync_evt,
  input  logic        ab_mode,
  input  logic        end_arr,
  input  logic        last_arr,
  output chan_state_e state,
  output logic        capture,
  output logic        step,
  output logic        done
);
  chan_state_e state_d;
  logic        done_d;

  always_comb begin
    state_d = state;
    capture = 1'b0;
    step    = 1'b0;
    done_d  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cfg_load && cfg_ok) begin
          capture = 1'b1;
          state_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (sync_evt) state_d = ST_RUN;
      end
      ST_RUN: begin
        step = 1'b1;
        if (end_arr) begin
          if (last_arr) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (!ab_mode) begin
            state_d = ST_ARMED;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/dma2d_addr_walk.sv
module dma2d_addr_walk
  import dma2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_BEAT = 8,
  localparam int LEN_W   = $clog2(MAX_BEAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  input  logic              step,
  input  logic [CNT_W-1:0]  acnt,
  input  logic [CNT_W-1:0]  bcnt,
  input  logic [IDX_W-1:0]  sidx,
  input  logic [IDX_W-1:0]  didx,
  output logic [ADDR_W-1:0] beat_src,
  output logic [ADDR_W-1:0] beat_dst,
  output logic [LEN_W-1:0]  beat_len,
  output logic              end_arr,
  output logic              last_arr
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BEAT);

  logic [ADDR_W-1:0] arr_src_q, arr_src_d;
  logic [ADDR_W-1:0] arr_dst_q, arr_dst_d;
  logic [CNT_W-1:0]  off_q, off_d;
  logic [CNT_W-1:0]  bidx_q, bidx_d;
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] sstride, dstride;

  assign sstride = {{(ADDR_W-IDX_W){sidx[IDX_W-1]}}, sidx};
  assign dstride = {{(ADDR_W-IDX_W){didx[IDX_W-1]}}, didx};

  assign remain   = acnt - off_q;
  assign end_arr  = (remain <= MAX_C);
  assign last_arr = (bidx_q == bcnt - 1'b1);
  assign beat_len = end_arr ? remain[LEN_W-1:0] : LEN_W'(MAX_BEAT);
  assign beat_src = arr_src_q + ADDR_W'(off_q);
  assign beat_dst = arr_dst_q + ADDR_W'(off_q);

  always_comb begin
    arr_src_d = arr_src_q;
    arr_dst_d = arr_dst_q;
    off_d     = off_q;
    bidx_d    = bidx_q;
    if (start) begin
      arr_src_d = start_src;
      arr_dst_d = start_dst;
      off_d     = '0;
      bidx_d    = '0;
    end else if (step) begin
      if (end_arr) begin
        off_d     = '0;
        bidx_d    = bidx_q + 1'b1;
        arr_src_d = arr_src_q + sstride;
        arr_dst_d = arr_dst_q + dstride;
      end else begin
        off_d = off_q + CNT_W'(beat_len);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_src_q <= '0;
      arr_dst_q <= '0;
      off_q     <= '0;
      bidx_q    <= '0;
    end else begin
      arr_src_q <= arr_src_d;
      arr_dst_q <= arr_dst_d;
      off_q     <= off_d;
      bidx_q    <= bidx_d;
    end
  end
endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
  import dma2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_BEAT = 8,
  localparam int LEN_W   = $clog2(MAX_BEAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [15:0]       cfg_acnt,
  input  logic [15:0]       cfg_bcnt,
  input  logic [15:0]       cfg_sidx,
  input  logic [15:0]       cfg_didx,
  input  logic              cfg_ab_sync,
  input  logic              sync_evt,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_src,
  output logic [ADDR_W-1:0] beat_dst,
  output logic [LEN_W-1:0]  beat_len,
  output logic              done
);
  logic [1:0]  rst_sync_q;
  logic        rst_q_n;
  chan_cfg_t   cfg_in, cfg_q;
  chan_state_e state;
  logic        capture, step, end_arr, last_arr, cfg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign cfg_in = '{acnt: cfg_acnt, bcnt: cfg_bcnt, sidx: cfg_sidx,
                    didx: cfg_didx, ab_mode: cfg_ab_sync};
  assign cfg_ok = (cfg_acnt != '0) && (cfg_bcnt != '0);

  dma2d_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_q_n), .capture(capture),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  dma2d_fsm u_fsm (
    .clk(clk), .rst_n(rst_q_n), .cfg_load(cfg_load), .cfg_ok(cfg_ok),
    .sync_evt(sync_evt), .ab_mode(cfg_q.ab_mode), .end_arr(end_arr),
    .last_arr(last_arr), .state(state), .capture(capture), .step(step),
    .done(done)
  );

  dma2d_addr_walk #(.ADDR_W(ADDR_W), .MAX_BEAT(MAX_BEAT)) u_walk (
    .clk(clk), .rst_n(rst_q_n), .start(capture),
    .start_src(cfg_src), .start_dst(cfg_dst), .step(step),
    .acnt(cfg_q.acnt), .bcnt(cfg_q.bcnt), .sidx(cfg_q.sidx),
    .didx(cfg_q.didx), .beat_src(beat_src), .beat_dst(beat_dst),
    .beat_len(beat_len), .end_arr(end_arr), .last_arr(last_arr)
  );

  assign beat_valid = (state == ST_RUN);
endmodule

// File: rtl/dma2d_addr_seq_chk.sv
module dma2d_addr_seq_chk
  import dma2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_BEAT = 8,
  localparam int LEN_W   = $clog2(MAX_BEAT + 1)
) (
  input logic              clk,
  input logic              rst_q_n,
  input chan_state_e       state,
  input logic              ab_mode,
  input logic              end_arr,
  input logic              last_arr,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_src,
  input logic [ADDR_W-1:0] beat_dst,
  input logic [LEN_W-1:0]  beat_len,
  input logic              done
);
  assert_beat_len_range_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    beat_valid |-> (beat_len != '0) && (beat_len <= LEN_W'(MAX_BEAT)));

  assert_linear_step_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (beat_valid && !end_arr) |=> beat_valid
      && (beat_src == $past(beat_src) + ADDR_W'($past(beat_len)))
      && (beat_dst == $past(beat_dst) + ADDR_W'($past(beat_len))));

  assert_frame_continuous_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (beat_valid && ab_mode && !(end_arr && last_arr)) |=> beat_valid);

  assert_one_array_per_event_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (beat_valid && !ab_mode && end_arr && !last_arr) |=> !beat_valid);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (beat_valid && end_arr && last_arr) |=> done && !beat_valid);

  assert_idle_ignores_event_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state == ST_IDLE) |=> !beat_valid);
endmodule

bind dma2d_addr_seq dma2d_addr_seq_chk #(.ADDR_W(ADDR_W), .MAX_BEAT(MAX_BEAT)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .state(state), .ab_mode(cfg_q.ab_mode),
  .end_arr(end_arr), .last_arr(last_arr), .beat_valid(beat_valid),
  .beat_src(beat_src), .beat_dst(beat_dst), .beat_len(beat_len), .done(done)
);

// File: tb/dma2d_addr_seq_test.sv
`timescale 1ns/1ps
module dma2d_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load, cfg_ab_sync, sync_evt;
  logic [31:0] cfg_src, cfg_dst;
  logic [15:0] cfg_acnt, cfg_bcnt, cfg_sidx, cfg_didx;
  logic        beat_valid, done;
  logic [31:0] beat_src, beat_dst;
  logic [3:0]  beat_len;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] m_src, m_dst;
  int          m_acnt, m_bcnt;
  logic [15:0] m_sidx, m_didx;

  always #2.5 clk = ~clk;

  dma2d_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_acnt(cfg_acnt), .cfg_bcnt(cfg_bcnt),
    .cfg_sidx(cfg_sidx), .cfg_didx(cfg_didx), .cfg_ab_sync(cfg_ab_sync),
    .sync_evt(sync_evt), .beat_valid(beat_valid), .beat_src(beat_src),
    .beat_dst(beat_dst), .beat_len(beat_len), .done(done)
  );

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] s, logic [31:0] d, int a, int b,
                         logic [15:0] si, logic [15:0] di, logic ab, bit accept);
    cfg_src = s; cfg_dst = d; cfg_acnt = a[15:0]; cfg_bcnt = b[15:0];
    cfg_sidx = si; cfg_didx = di; cfg_ab_sync = ab; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    if (accept) begin
      m_src = s; m_dst = d; m_acnt = a; m_bcnt = b; m_sidx = si; m_didx = di;
    end
  endtask

  task automatic pulse_evt();
    sync_evt = 1'b1;
    @(negedge clk);
    sync_evt = 1'b0;
  endtask

  task automatic expect_array(string tag);
    int off = 0;
    while (off < m_acnt) begin
      int len = (m_acnt - off > 8) ? 8 : m_acnt - off;
      check_eq({tag, " valid"}, 32'(beat_valid), 32'd1);
      check_eq({tag, " src"}, beat_src, m_src + 32'(off));
      check_eq({tag, " dst"}, beat_dst, m_dst + 32'(off));
      check_eq({tag, " len"}, 32'(beat_len), 32'(len));
      off += len;
      @(negedge clk);
    end
    m_src = m_src + {{16{m_sidx[15]}}, m_sidx};
    m_dst = m_dst + {{16{m_didx[15]}}, m_didx};
  endtask

  task automatic expect_quiet(string tag, int n);
    for (int i = 0; i < n; i++) begin
      check_eq({tag, " no beat"}, 32'(beat_valid), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic expect_done(string tag);
    check_eq({tag, " done high"}, 32'(done), 32'd1);
    check_eq({tag, " valid low at done"}, 32'(beat_valid), 32'd0);
    @(negedge clk);
    check_eq({tag, " done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    check_eq("R6 reset beat_valid", 32'(beat_valid), 32'd0);
    check_eq("R6 reset done", 32'(done), 32'd0);
  endtask

  task automatic t_idle_event();
    pulse_evt();
    expect_quiet("R7 idle event", 3);
  endtask

  task automatic t_fixed_read();
    do_load(32'h1000_0000, 32'h0000_8000, 8, 4, 16'd0, 16'd8, 1'b1, 1);
    pulse_evt();
    for (int k = 0; k < 4; k++) expect_array("R3 R4 fixed source");
    expect_done("R6 fixed source");
  endtask

  task automatic t_fixed_write();
    do_load(32'h0000_9000, 32'h2000_0000, 8, 3, 16'd8, 16'd0, 1'b1, 1);
    pulse_evt();
    for (int k = 0; k < 3; k++) expect_array("R3 R4 fixed destination");
    expect_done("R6 fixed destination");
  endtask

  task automatic t_array_mode();
    do_load(32'h0000_0100, 32'h0000_5000, 20, 3, 16'd100, 16'hFFCE, 1'b0, 1);
    for (int k = 0; k < 3; k++) begin
      pulse_evt();
      expect_array("R2 R5 R8 array mode");
      if (k < 2) begin
        check_eq("R5 no done mid frame", 32'(done), 32'd0);
        expect_quiet("R5 wait for event", 3);
      end else begin
        expect_done("R6 array mode");
      end
    end
  endtask

  task automatic t_held_event();
    do_load(32'h0000_4000, 32'h0000_0200, 5, 3, 16'hFFF0, 16'd5, 1'b1, 1);
    sync_evt = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) expect_array("R7 R8 held event");
    expect_done("R7 held event");
    expect_quiet("R7 event after done", 3);
    sync_evt = 1'b0;
  endtask

  task automatic t_load_rules();
    do_load(32'h0000_1111, 32'h0000_2222, 0, 4, 16'd1, 16'd1, 1'b1, 0);
    pulse_evt();
    expect_quiet("R1 zero length load", 3);
    do_load(32'h0000_1111, 32'h0000_2222, 6, 0, 16'd1, 16'd1, 1'b1, 0);
    pulse_evt();
    expect_quiet("R1 zero count load", 3);
    do_load(32'h0000_3000, 32'h0000_6000, 4, 2, 16'd4, 16'd0, 1'b0, 1);
    do_load(32'h0000_7777, 32'h0000_8888, 8, 5, 16'd9, 16'd9, 1'b1, 0);
    pulse_evt();
    expect_array("R1 load while armed ignored");
    expect_quiet("R1 array mode pause", 2);
    pulse_evt();
    expect_array("R1 second array");
    expect_done("R1 frame end");
  endtask

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; sync_evt = 1'b0; cfg_ab_sync = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_acnt = '0; cfg_bcnt = '0;
    cfg_sidx = '0; cfg_didx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_event();
    t_fixed_read();
    t_fixed_write();
    t_array_mode();
    t_held_event();
    t_load_rules();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule